// File: doc/BRIEF.md
# Compressed instruction expander

This block turns a 16-bit compressed instruction for a 32-bit integer base into the full-width 32-bit instruction that does the same thing. The rest of the decode pipeline then only has to handle one format. Bits [1:0] of the incoming word choose the path. The values 00, 01 and 10 select one of three compressed quadrants, which are expanded. The value 11 marks a full-width instruction, which is forwarded untouched.

The expander covers stack-relative word loads and stores, and word loads and stores that use the eight-register short form. It also covers jumps, conditional branches, immediate loads, register-immediate and register-register integer operations, the no-op and the breakpoint. Reserved encodings, custom shift encodings and encodings that belong to wider bases or to floating point are flagged illegal. HINT encodings expand to base instructions that change no architectural state.

The expansion logic is purely combinational. It sits in front of one pipeline register with a valid bit, so the result appears one clock after the input is presented.

Top module: `cinstr_expander`

## Requirements
- R1: When `in_word[1:0]` is 11, `out_word` equals `in_word`, `out_illegal` is 0 and `out_compressed` is 0.
- R2: When `in_word[1:0]` is not 11, `in_word[31:16]` has no effect on the result and `out_compressed` is 1.
- R3: A 3-bit short register field `r` names integer register 8+r, so 000 is x8 and 111 is x15. A short-form word load or store uses a zero-extended offset scaled by 4, with a range of 0 to 124.
- R4: Stack-relative word loads and stores use x2 as the base, with a zero-extended offset scaled by 4 (0 to 252). A stack load whose destination is x0 is illegal.
- R5: The stack pointer-generation form (quadrant 00, funct3 000) adds a zero-extended immediate scaled by 4 (4 to 1020) to x2. A zero immediate, including the all-zero word, is illegal.
- R6: The unconditional jump expands to a jal with rd x0. The jump-and-link form expands to a jal with rd x1. Both carry the 12-bit offset sign-extended, with its bits placed back in order from their scattered field positions.
- R7: The branch-if-zero and branch-if-nonzero forms expand to beq or bne against x0, with a sign-extended 9-bit offset.
- R8: The immediate load form expands to addi rd,x0,imm. On the upper-immediate opcode, rd x2 selects a stack adjust of imm*16 (range -512 to 496), while any other rd gives lui with the 6-bit immediate at bits 17:12, sign-extended from bit 17. A zero immediate on either form is illegal.
- R9: Immediate shifts (slli, srli, srai), andi and addi expand to their base forms. A shift encoding with shamt bit 5 set is illegal.
- R10: The short register-register group expands to sub, xor, or and and on x8 to x15. The encodings with instruction bit 12 set in that group are illegal.
- R11: In quadrant 10 with funct3 100, the expansion depends on bit 12 and on whether the rs2 field or the rd field is zero:
  - bit 12 = 0, rs2 != 0: mv, which gives add rd,x0,rs2.
  - bit 12 = 0, rs2 = 0, rd != 0: register jump, which gives jalr x0,0(rd).
  - bit 12 = 0, rs2 = 0, rd = 0: illegal.
  - bit 12 = 1, rs2 != 0: add rd,rd,rs2.
  - bit 12 = 1, rs2 = 0, rd != 0: jalr x1,0(rd).
  - bit 12 = 1, rs2 = 0, rd = 0: ebreak, 32'h00100073.
- R12: HINT encodings expand to base instructions and are not illegal. These are immediate load to x0, add or move to x0, addi with a zero immediate, and the no-op with a nonzero immediate.
- R13: Encodings outside the supported set are illegal. These include the floating-point and wide-base slots of quadrants 00 and 10. Whenever `out_illegal` is 1, `out_word` is 0.
- R14: Results appear one clock after `in_valid` and are held while `in_valid` is low. A synchronous reset clears `out_valid`, `out_word`, `out_illegal` and `out_compressed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_word | input | 32 | Fetched word. Only bits 15:0 matter when bits 1:0 are not 11 |
| out_valid | output | 1 | Registered result is valid |
| out_word | output | 32 | Expanded or forwarded 32-bit instruction |
| out_illegal | output | 1 | The input encoding is not decodable |
| out_compressed | output | 1 | The input was a 16-bit form |

## Verification
The decode holds no state beyond the output register. A wrong field unscramble, a wrong register offset or a mis-resolved shared opcode therefore shows up in `out_word` exactly one cycle after the offending input, and only for the encodings that reach the faulty path. The reference table is built to reach those paths. It uses all-ones and single-bit offsets, so each scattered immediate bit is visible on its own. It also covers each zero-register and zero-immediate split, and each reserved slot. A fault in the valid or hold logic shows up on the cycle after `in_valid` drops or reset is raised.

// File: rtl/cexp_pkg.sv
package cexp_pkg;

    localparam int ILEN  = 32;
    localparam int CLEN  = 16;
    localparam int RIDX  = 5;
    localparam int CRIDX = 3;
    localparam int OPW   = 7;
    localparam int F3W   = 3;
    localparam int IMMI  = 12;
    localparam int IMMB  = 13;
    localparam int IMMJ  = 21;
    localparam int IMMU  = 20;

    typedef logic [ILEN-1:0] word_t;
    typedef logic [CLEN-1:2] body_t;
    typedef logic [RIDX-1:0] reg_t;
    typedef logic [F3W-1:0]  f3_t;
    typedef logic [OPW-1:0]  opc_t;

    typedef enum logic [1:0] {
        QD_ZERO = 2'b00,
        QD_ONE  = 2'b01,
        QD_TWO  = 2'b10,
        QD_FULL = 2'b11
    } quad_e;

    typedef struct packed {
        word_t word;
        logic  bad;
    } xres_t;

    localparam opc_t OPC_LOAD   = 7'b0000011;
    localparam opc_t OPC_STORE  = 7'b0100011;
    localparam opc_t OPC_OPIMM  = 7'b0010011;
    localparam opc_t OPC_OP     = 7'b0110011;
    localparam opc_t OPC_LUI    = 7'b0110111;
    localparam opc_t OPC_JAL    = 7'b1101111;
    localparam opc_t OPC_JALR   = 7'b1100111;
    localparam opc_t OPC_BRANCH = 7'b1100011;

    localparam reg_t REG_ZERO = 5'd0;
    localparam reg_t REG_LINK = 5'd1;
    localparam reg_t REG_SP   = 5'd2;

    localparam word_t WORD_BREAK = 32'h0010_0073;

    // Short register field names x8..x15
    function automatic reg_t prime_reg(input logic [CRIDX-1:0] r);
        return {2'b01, r};
    endfunction

    function automatic word_t pack_i(input logic [IMMI-1:0] imm, input reg_t rs1,
                                     input f3_t f3, input reg_t rd, input opc_t opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    function automatic word_t pack_s(input logic [IMMI-1:0] imm, input reg_t rs2,
                                     input reg_t rs1, input f3_t f3, input opc_t opc);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
    endfunction

    function automatic word_t pack_b(input logic [IMMB-1:0] imm, input reg_t rs2,
                                     input reg_t rs1, input f3_t f3);
        return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
    endfunction

    function automatic word_t pack_j(input logic [IMMJ-1:0] imm, input reg_t rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
    endfunction

    function automatic word_t pack_r(input logic [6:0] f7, input reg_t rs2, input reg_t rs1,
                                     input f3_t f3, input reg_t rd);
        return {f7, rs2, rs1, f3, rd, OPC_OP};
    endfunction

    function automatic word_t pack_u(input logic [IMMU-1:0] imm, input reg_t rd);
        return {imm, rd, OPC_LUI};
    endfunction

    function automatic xres_t good(input word_t w);
        xres_t r;
        r.word = w;
        r.bad  = 1'b0;
        return r;
    endfunction

    function automatic xres_t reject();
        xres_t r;
        r.word = '0;
        r.bad  = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/cexp_quad0.sv
module cexp_quad0
    import cexp_pkg::*;
(
    input  body_t c,
    output xres_t res
);

    logic [9:0] spn_imm;
    logic [6:0] wofs;
    reg_t       rd_p;
    reg_t       rs1_p;

    always_comb begin
        spn_imm      = '0;
        spn_imm[9:6] = c[10:7];
        spn_imm[5:4] = c[12:11];
        spn_imm[3]   = c[5];
        spn_imm[2]   = c[6];

        wofs      = '0;
        wofs[6]   = c[5];
        wofs[5:3] = c[12:10];
        wofs[2]   = c[6];

        rd_p  = prime_reg(c[4:2]);
        rs1_p = prime_reg(c[9:7]);
    end

    always_comb begin
        unique case (c[15:13])
            3'b000: begin
                if (spn_imm == '0)
                    res = reject();
                else
                    res = good(pack_i({2'b00, spn_imm}, REG_SP, 3'b000, rd_p, OPC_OPIMM));
            end
            3'b010:
                res = good(pack_i({5'b0, wofs}, rs1_p, 3'b010, rd_p, OPC_LOAD));
            3'b110:
                res = good(pack_s({5'b0, wofs}, rd_p, rs1_p, 3'b010, OPC_STORE));
            default:
                res = reject();
        endcase
    end

endmodule

// File: rtl/cexp_quad1.sv
module cexp_quad1
    import cexp_pkg::*;
(
    input  body_t c,
    output xres_t res
);

    logic [IMMI-1:0] simm;
    logic [11:0]     jofs;
    logic [8:0]      bofs;
    logic [9:0]      spadj;
    logic [IMMU-1:0] uimm;
    logic            imm_zero;
    reg_t            rd_full;
    reg_t            rd_p;
    reg_t            rs2_p;
    logic [4:0]      shamt;

    always_comb begin
        simm     = {{6{c[12]}}, c[12], c[6:2]};
        imm_zero = (c[12] == 1'b0) && (c[6:2] == 5'd0);
        rd_full  = c[11:7];
        rd_p     = prime_reg(c[9:7]);
        rs2_p    = prime_reg(c[4:2]);
        shamt    = c[6:2];

        jofs      = '0;
        jofs[11]  = c[12];
        jofs[10]  = c[8];
        jofs[9:8] = c[10:9];
        jofs[7]   = c[6];
        jofs[6]   = c[7];
        jofs[5]   = c[2];
        jofs[4]   = c[11];
        jofs[3:1] = c[5:3];

        bofs      = '0;
        bofs[8]   = c[12];
        bofs[7:6] = c[6:5];
        bofs[5]   = c[2];
        bofs[4:3] = c[11:10];
        bofs[2:1] = c[4:3];

        spadj      = '0;
        spadj[9]   = c[12];
        spadj[8:7] = c[4:3];
        spadj[6]   = c[5];
        spadj[5]   = c[2];
        spadj[4]   = c[6];

        uimm = {{14{c[12]}}, c[12], c[6:2]};
    end

    always_comb begin
        unique case (c[15:13])
            3'b000:
                res = good(pack_i(simm, rd_full, 3'b000, rd_full, OPC_OPIMM));
            3'b001:
                res = good(pack_j({{9{jofs[11]}}, jofs}, REG_LINK));
            3'b010:
                res = good(pack_i(simm, REG_ZERO, 3'b000, rd_full, OPC_OPIMM));
            3'b011: begin
                if (imm_zero)
                    res = reject();
                else if (rd_full == REG_SP)
                    res = good(pack_i({{2{spadj[9]}}, spadj}, REG_SP, 3'b000, REG_SP, OPC_OPIMM));
                else
                    res = good(pack_u(uimm, rd_full));
            end
            3'b100: begin
                unique case (c[11:10])
                    2'b00: begin
                        if (c[12])
                            res = reject();
                        else
                            res = good(pack_i({7'b0000000, shamt}, rd_p, 3'b101, rd_p, OPC_OPIMM));
                    end
                    2'b01: begin
                        if (c[12])
                            res = reject();
                        else
                            res = good(pack_i({7'b0100000, shamt}, rd_p, 3'b101, rd_p, OPC_OPIMM));
                    end
                    2'b10:
                        res = good(pack_i(simm, rd_p, 3'b111, rd_p, OPC_OPIMM));
                    default: begin
                        if (c[12]) begin
                            res = reject();
                        end else begin
                            unique case (c[6:5])
                                2'b00:   res = good(pack_r(7'b0100000, rs2_p, rd_p, 3'b000, rd_p));
                                2'b01:   res = good(pack_r(7'b0000000, rs2_p, rd_p, 3'b100, rd_p));
                                2'b10:   res = good(pack_r(7'b0000000, rs2_p, rd_p, 3'b110, rd_p));
                                default: res = good(pack_r(7'b0000000, rs2_p, rd_p, 3'b111, rd_p));
                            endcase
                        end
                    end
                endcase
            end
            3'b101:
                res = good(pack_j({{9{jofs[11]}}, jofs}, REG_ZERO));
            3'b110:
                res = good(pack_b({{4{bofs[8]}}, bofs}, REG_ZERO, rd_p, 3'b000));
            default:
                res = good(pack_b({{4{bofs[8]}}, bofs}, REG_ZERO, rd_p, 3'b001));
        endcase
    end

endmodule

// File: rtl/cexp_quad2.sv
module cexp_quad2
    import cexp_pkg::*;
(
    input  body_t c,
    output xres_t res
);

    reg_t       rd_full;
    reg_t       rs2_full;
    logic [7:0] lsp;
    logic [7:0] ssp;
    logic [4:0] shamt;

    always_comb begin
        rd_full  = c[11:7];
        rs2_full = c[6:2];
        shamt    = c[6:2];

        lsp      = '0;
        lsp[7:6] = c[3:2];
        lsp[5]   = c[12];
        lsp[4:2] = c[6:4];

        ssp      = '0;
        ssp[7:6] = c[8:7];
        ssp[5:2] = c[12:9];
    end

    always_comb begin
        unique case (c[15:13])
            3'b000: begin
                if (c[12])
                    res = reject();
                else
                    res = good(pack_i({7'b0000000, shamt}, rd_full, 3'b001, rd_full, OPC_OPIMM));
            end
            3'b010: begin
                if (rd_full == REG_ZERO)
                    res = reject();
                else
                    res = good(pack_i({4'b0, lsp}, REG_SP, 3'b010, rd_full, OPC_LOAD));
            end
            3'b100: begin
                if (!c[12]) begin
                    if (rs2_full != REG_ZERO)
                        res = good(pack_r(7'b0000000, rs2_full, REG_ZERO, 3'b000, rd_full));
                    else if (rd_full != REG_ZERO)
                        res = good(pack_i(12'd0, rd_full, 3'b000, REG_ZERO, OPC_JALR));
                    else
                        res = reject();
                end else begin
                    if (rs2_full != REG_ZERO)
                        res = good(pack_r(7'b0000000, rs2_full, rd_full, 3'b000, rd_full));
                    else if (rd_full != REG_ZERO)
                        res = good(pack_i(12'd0, rd_full, 3'b000, REG_LINK, OPC_JALR));
                    else
                        res = good(WORD_BREAK);
                end
            end
            3'b110:
                res = good(pack_s({4'b0, ssp}, rs2_full, REG_SP, 3'b010, OPC_STORE));
            default:
                res = reject();
        endcase
    end

endmodule

// File: rtl/cinstr_expander.sv
module cinstr_expander
    import cexp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_word,
    output logic        out_valid,
    output logic [31:0] out_word,
    output logic        out_illegal,
    output logic        out_compressed
);

    body_t body;
    quad_e quad;
    xres_t res_q0;
    xres_t res_q1;
    xres_t res_q2;
    xres_t sel;
    logic  is_short;

    assign body     = in_word[CLEN-1:2];
    assign quad     = quad_e'(in_word[1:0]);
    assign is_short = (quad != QD_FULL);

    cexp_quad0 u_q0 (.c(body), .res(res_q0));
    cexp_quad1 u_q1 (.c(body), .res(res_q1));
    cexp_quad2 u_q2 (.c(body), .res(res_q2));

    always_comb begin
        unique case (quad)
            QD_ZERO: sel = res_q0;
            QD_ONE:  sel = res_q1;
            QD_TWO:  sel = res_q2;
            default: sel = good(in_word);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_word       <= '0;
            out_illegal    <= 1'b0;
            out_compressed <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word       <= sel.word;
                out_illegal    <= sel.bad;
                out_compressed <= is_short;
            end
        end
    end

endmodule

// File: rtl/cinstr_expander_chk.sv
module cinstr_expander_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_word,
    input logic        out_valid,
    input logic [31:0] out_word,
    input logic        out_illegal,
    input logic        out_compressed
);

    AST_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[1:0] == 2'b11) |=> (out_word == $past(in_word) && !out_illegal)); // R1

    AST_SHORT_FLAG: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_compressed == ($past(in_word[1:0]) != 2'b11))); // R2

    AST_LOAD_SP_X0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[1:0] == 2'b10 && in_word[15:13] == 3'b010 && in_word[11:7] == 5'd0)
        |=> out_illegal); // R4

    AST_ZERO_SPN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[1:0] == 2'b00 && in_word[15:5] == 11'd0) |=> out_illegal); // R5

    AST_CUSTOM_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[1:0] == 2'b01 && in_word[15:13] == 3'b100 && in_word[11] == 1'b0
         && in_word[12]) |=> out_illegal); // R9

    AST_WIDE_ALU: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[1:0] == 2'b01 && in_word[15:10] == 6'b100111) |=> out_illegal); // R10

    AST_BREAK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[15:0] == 16'h9002) |=> (out_word == 32'h0010_0073 && !out_illegal)); // R11

    AST_ILLEGAL_BLANK: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_word == 32'd0)); // R13

    AST_SHORT_FULLFORM: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_compressed && !out_illegal) |-> (out_word[1:0] == 2'b11)); // R13

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_word))); // R14

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_word == 32'd0 && !out_illegal)); // R14

endmodule

bind cinstr_expander cinstr_expander_chk u_chk (
    .clk(clk),
    .rst(rst),
    .in_valid(in_valid),
    .in_word(in_word),
    .out_valid(out_valid),
    .out_word(out_word),
    .out_illegal(out_illegal),
    .out_compressed(out_compressed)
);

// File: tb/tb_cinstr_expander.sv
module tb_cinstr_expander;

    logic        clk;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_word;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_illegal;
    logic        out_compressed;

    int n_checks;
    int n_fails;
    bit finished;

    cinstr_expander dut (
        .clk(clk),
        .rst(rst),
        .in_valid(in_valid),
        .in_word(in_word),
        .out_valid(out_valid),
        .out_word(out_word),
        .out_illegal(out_illegal),
        .out_compressed(out_compressed)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // {req, input, expected word, expected illegal, expected compressed}
    localparam int NV = 52;
    localparam logic [73:0] VEC [NV] = '{
        {8'd1,  32'h00A5_0533, 32'h00A5_0533, 1'b0, 1'b0}, // R1 full add
        {8'd1,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R1
        {8'd5,  32'h0000_0040, 32'h0041_0413, 1'b0, 1'b1}, // R5 imm 4
        {8'd5,  32'h0000_1FFC, 32'h3FC1_0793, 1'b0, 1'b1}, // R5 imm 1020
        {8'd5,  32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1}, // R5 all zero
        {8'd3,  32'h0000_5D64, 32'h07C5_2483, 1'b0, 1'b1}, // R3 lw 124
        {8'd3,  32'h0000_C22C, 32'h04B6_2023, 1'b0, 1'b1}, // R3 sw 64
        {8'd3,  32'h0000_401C, 32'h0004_2783, 1'b0, 1'b1}, // R3 x15/x8
        {8'd12, 32'h0000_0001, 32'h0000_0013, 1'b0, 1'b1}, // R12 nop
        {8'd2,  32'hDEAD_0001, 32'h0000_0013, 1'b0, 1'b1}, // R2 upper ignored
        {8'd9,  32'h0000_1281, 32'hFE02_8293, 1'b0, 1'b1}, // R9 addi -32
        {8'd12, 32'h0000_0281, 32'h0002_8293, 1'b0, 1'b1}, // R12 addi 0
        {8'd6,  32'h0000_3FFD, 32'hFFFF_F0EF, 1'b0, 1'b1}, // R6 jal -2
        {8'd6,  32'h0000_AFFD, 32'h7FE0_006F, 1'b0, 1'b1}, // R6 j 2046
        {8'd6,  32'h0000_A801, 32'h0100_006F, 1'b0, 1'b1}, // R6 j 16
        {8'd6,  32'h0000_A081, 32'h0400_006F, 1'b0, 1'b1}, // R6 j 64
        {8'd8,  32'h0000_457D, 32'h01F0_0513, 1'b0, 1'b1}, // R8 li 31
        {8'd12, 32'h0000_4005, 32'h0010_0013, 1'b0, 1'b1}, // R12 li x0
        {8'd8,  32'h0000_71FD, 32'hFFFF_F1B7, 1'b0, 1'b1}, // R8 lui -1
        {8'd8,  32'h0000_6185, 32'h0000_11B7, 1'b0, 1'b1}, // R8 lui 1
        {8'd8,  32'h0000_6181, 32'h0000_0000, 1'b1, 1'b1}, // R8 lui 0
        {8'd8,  32'h0000_7101, 32'hE001_0113, 1'b0, 1'b1}, // R8 sp -512
        {8'd8,  32'h0000_6141, 32'h0101_0113, 1'b0, 1'b1}, // R8 sp 16
        {8'd8,  32'h0000_6101, 32'h0000_0000, 1'b1, 1'b1}, // R8 sp 0
        {8'd9,  32'h0000_800D, 32'h0034_5413, 1'b0, 1'b1}, // R9 srli
        {8'd9,  32'h0000_84FD, 32'h41F4_D493, 1'b0, 1'b1}, // R9 srai 31
        {8'd9,  32'h0000_9005, 32'h0000_0000, 1'b1, 1'b1}, // R9 shamt5
        {8'd9,  32'h0000_997D, 32'hFFF5_7513, 1'b0, 1'b1}, // R9 andi -1
        {8'd10, 32'h0000_8C05, 32'h4094_0433, 1'b0, 1'b1}, // R10 sub
        {8'd10, 32'h0000_8C25, 32'h0094_4433, 1'b0, 1'b1}, // R10 xor
        {8'd10, 32'h0000_8C45, 32'h0094_6433, 1'b0, 1'b1}, // R10 or
        {8'd10, 32'h0000_8C65, 32'h0094_7433, 1'b0, 1'b1}, // R10 and
        {8'd10, 32'h0000_9C05, 32'h0000_0000, 1'b1, 1'b1}, // R10 bit12
        {8'd7,  32'h0000_D001, 32'hF004_00E3, 1'b0, 1'b1}, // R7 beq -256
        {8'd7,  32'h0000_E389, 32'h0007_9163, 1'b0, 1'b1}, // R7 bne +2
        {8'd9,  32'h0000_0086, 32'h0010_9093, 1'b0, 1'b1}, // R9 slli 1
        {8'd9,  32'h0000_1086, 32'h0000_0000, 1'b1, 1'b1}, // R9 slli shamt5
        {8'd4,  32'h0000_50FE, 32'h0FC1_2083, 1'b0, 1'b1}, // R4 lw 252(sp)
        {8'd4,  32'h0000_4002, 32'h0000_0000, 1'b1, 1'b1}, // R4 rd x0
        {8'd4,  32'h0000_C27E, 32'h01F1_2223, 1'b0, 1'b1}, // R4 sw 4(sp)
        {8'd4,  32'h0000_DF86, 32'h0E11_2E23, 1'b0, 1'b1}, // R4 sw 252(sp)
        {8'd11, 32'h0000_8082, 32'h0000_8067, 1'b0, 1'b1}, // R11 jr x1
        {8'd11, 32'h0000_8002, 32'h0000_0000, 1'b1, 1'b1}, // R11 jr x0
        {8'd11, 32'h0000_852E, 32'h00B0_0533, 1'b0, 1'b1}, // R11 mv
        {8'd12, 32'h0000_802E, 32'h00B0_0033, 1'b0, 1'b1}, // R12 mv x0
        {8'd11, 32'h0000_9002, 32'h0010_0073, 1'b0, 1'b1}, // R11 ebreak
        {8'd11, 32'h0000_9282, 32'h0002_80E7, 1'b0, 1'b1}, // R11 jalr x5
        {8'd11, 32'h0000_952E, 32'h00B5_0533, 1'b0, 1'b1}, // R11 add
        {8'd12, 32'h0000_902E, 32'h00B0_0033, 1'b0, 1'b1}, // R12 add x0
        {8'd13, 32'h0000_2000, 32'h0000_0000, 1'b1, 1'b1}, // R13 q0 f3=001
        {8'd13, 32'h0000_6082, 32'h0000_0000, 1'b1, 1'b1}, // R13 q2 f3=011
        {8'd13, 32'h0000_E000, 32'h0000_0000, 1'b1, 1'b1}  // R13 q0 f3=111
    };

    task automatic check(input int req, input logic ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        n_checks = 0;
        n_fails  = 0;
        finished = 1'b0;
        rst      = 1'b1;
        in_valid = 1'b0;
        in_word  = 32'h0;
        repeat (3) @(negedge clk);

        // R14 reset state
        check(14, out_valid == 1'b0, "reset valid", {31'd0, out_valid}, 32'd0);
        check(14, out_word == 32'd0 && !out_illegal && !out_compressed, "reset word",
              out_word, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [73:0] v;
            int req;
            v   = VEC[i];
            req = int'(v[73:66]);
            in_valid = 1'b1;
            in_word  = v[65:34];
            @(negedge clk);
            check(req, out_valid, "valid", {31'd0, out_valid}, 32'd1);
            check(req, out_word == v[33:2], "word", out_word, v[33:2]);
            check(req, out_illegal == v[1], "illegal", {31'd0, out_illegal}, {31'd0, v[1]});
            check(req, out_compressed == v[0], "compressed (R2)",
                  {31'd0, out_compressed}, {31'd0, v[0]});
        end

        // R14 hold while in_valid is low
        in_valid = 1'b1;
        in_word  = 32'h0000_457D;
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = 32'h0000_9002;
        @(negedge clk);
        check(14, out_valid == 1'b0, "valid drops", {31'd0, out_valid}, 32'd0);
        check(14, out_word == 32'h01F0_0513, "hold word", out_word, 32'h01F0_0513);
        @(negedge clk);
        check(14, out_word == 32'h01F0_0513, "hold second", out_word, 32'h01F0_0513);

        // R14 reset mid-run clears a held illegal result
        in_valid = 1'b1;
        in_word  = 32'h0000_8002;
        @(negedge clk);
        check(11, out_illegal == 1'b1, "jr x0 illegal", {31'd0, out_illegal}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        check(14, !out_valid && out_word == 32'd0 && !out_illegal, "reset clear",
              out_word, 32'd0);
        rst      = 1'b0;
        in_word  = 32'h0000_0001;
        @(negedge clk);
        check(12, out_word == 32'h0000_0013 && out_valid, "after reset", out_word, 32'h0000_0013);

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R14 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

endmodule